// File: doc/BRIEF.md
# Multiplexed Host Register Interface

This block is the slave side of an 8-bit parallel host bus on which address and data share the same wires. The host first runs a write with the select line high, which loads a register index. It then runs a data cycle with the select line low, which reads or writes the register that index points to. The block handles the strobe synchronisation, keeps the index latch, decodes the register map, holds the simple configuration registers, and passes accesses to the CAM data, bus control and PID table data registers on to neighbouring logic through a one-cycle internal read/write port.

A busy indication, active-low ready, is driven high for a fixed number of clocks after every accepted strobe, so that slow neighbours can answer reads. The block also keeps one interrupt-pending flag, raises an active-low interrupt line while that flag is set and enabled, and clears the flag when the host reads the interrupt control register.

Top module: `hbus_regif`

## Requirements
- R1: A bus cycle is accepted once, on the assertion of the synchronised strobe. Holding the strobe for any length of time produces exactly one access.
- R2: A write with `bus_sel` high loads the register index from `bus_din`. A read with `bus_sel` high returns the current index.
- R3: Data writes (`bus_sel` low) to the local indices 0x01, 0x04, 0x05, 0x08, 0x09, 0x0C and 0x0D store the byte, which reads back unchanged. `cam_addr` is {0x05,0x04}, `pid_addr` is {0x09,0x08}, `div_a` is 0x0C and `div_b` is 0x0D.
- R4: The indices 0x06, 0x07 and 0x0A are forwarded, with `ext_sel` codes 0, 1 and 2 respectively. A data write gives one `ext_wr` pulse of one cycle, with the code and the byte. A data read gives one `ext_rd` pulse and returns `ext_rdata` sampled at the end of the wait period. `ext_wr` and `ext_rd` are never high together.
- R5: Index 0x0F reads as the `REV` parameter, and writes to it change nothing.
- R6: Every other index reads as 0x00. A write to such an index changes no register and produces no `ext_wr`.
- R7: `bus_rdy_n` goes high on the clock edge that accepts a strobe and stays high for `WAIT_CYC` clocks. At all other times it is low. Read data is valid on `bus_dout` once it is low again.
- R8: A pulse on `irq_event` sets the pending flag. `irq_n` is low exactly while the flag is set and bit 6 of interrupt control (index 0x00) is set. Index 0x00 reads back the stored bits 7:1 with the pending flag in bit 0. Such a read clears the flag, unless a new event arrives on the same clock.
- R9: After reset, every register and the index are 0x00, `irq_n` is high, `bus_rdy_n` is low, and `ts_en` and `tuner_rst_n` are 0.
- R10: Within bus control 2 (index 0x01), bits 5:4 drive `ts_en[1:0]` and bits 3:2 drive `tuner_rst_n[1:0]`. A 0 in one of bits 3:2 holds that tuner in reset. These outputs change only on a write to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_sel | input | 1 | High: index cycle, low: data cycle |
| bus_din | input | 8 | Byte from the host |
| bus_dout | output | 8 | Byte to the host |
| bus_oe | output | 1 | High while a synchronised read is in progress |
| bus_rdy_n | output | 1 | Busy while high, ready while low |
| irq_event | input | 1 | Interrupt source pulse |
| irq_n | output | 1 | Interrupt request, active low |
| ts_en | output | 2 | Transport stream output enables |
| tuner_rst_n | output | 2 | Tuner reset controls, active low |
| cam_addr | output | 16 | CAM access address |
| pid_addr | output | 16 | PID table address |
| div_a | output | 8 | Stream A clock divider |
| div_b | output | 8 | Stream B clock divider |
| ext_wr | output | 1 | Forwarded write pulse |
| ext_rd | output | 1 | Forwarded read pulse |
| ext_sel | output | 2 | Forwarded register code |
| ext_wdata | output | 8 | Forwarded write byte |
| ext_rdata | input | 8 | Read byte from the forwarded register |

## Verification
Two situations are hard to reach from the ports. The first is a strobe held far longer than the synchroniser and wait window, which is where a level-sensitive design would repeat an access. The bench stretches one data write over dozens of clocks and counts the forwarded pulses. The second is proof that an unmapped write touched nothing. For this the bench sweeps all 256 indices, writing a value derived from each index. It then reads every index back and checks the divider and address outputs against values computed from the index. A stray write would have overwritten a neighbouring register with a different derived value, so it would show up in that read-back.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   localparam logic [7:0] IDX_INTCTL    = 8'h00;
   localparam logic [7:0] IDX_BUSCTL2   = 8'h01;
   localparam logic [7:0] IDX_CAMADR_LO = 8'h04;
   localparam logic [7:0] IDX_CAMADR_HI = 8'h05;
   localparam logic [7:0] IDX_CAMDATA   = 8'h06;
   localparam logic [7:0] IDX_BUSCTL    = 8'h07;
   localparam logic [7:0] IDX_PIDADR_LO = 8'h08;
   localparam logic [7:0] IDX_PIDADR_HI = 8'h09;
   localparam logic [7:0] IDX_PIDDATA   = 8'h0A;
   localparam logic [7:0] IDX_DIV_A     = 8'h0C;
   localparam logic [7:0] IDX_DIV_B     = 8'h0D;
   localparam logic [7:0] IDX_REV       = 8'h0F;

   localparam logic [1:0] EXT_CAMDATA = 2'd0;
   localparam logic [1:0] EXT_BUSCTL  = 2'd1;
   localparam logic [1:0] EXT_PIDDATA = 2'd2;

   typedef struct packed {
      logic       is_ext;
      logic [1:0] code;
   } ext_dec_t;

   function automatic ext_dec_t ext_decode(input logic [7:0] idx);
      ext_dec_t d;
      d.is_ext = 1'b1;
      d.code   = EXT_CAMDATA;
      case (idx)
         IDX_CAMDATA: d.code = EXT_CAMDATA;
         IDX_BUSCTL:  d.code = EXT_BUSCTL;
         IDX_PIDDATA: d.code = EXT_PIDDATA;
         default:     d.is_ext = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int         STAGES    = 2,
   parameter int         N         = 3,
   parameter logic [N-1:0] RESET_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] sync_o
);
   logic [N-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("hbus_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RESET_VAL;
      else        stg[0] <= async_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[g] <= RESET_VAL;
         else        stg[g] <= stg[g-1];
      end
   end

   assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/hbus_strobe.sv
module hbus_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic wr_n_s,
   input  logic rd_n_s,
   output logic wr_go,
   output logic rd_go,
   output logic rd_active
);
   logic wr_act, rd_act;
   logic wr_prev, rd_prev;

   // a write strobe takes precedence if both strobes are low
   assign wr_act = ~cs_n_s & ~wr_n_s;
   assign rd_act = ~cs_n_s & ~rd_n_s & wr_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= 1'b0;
         rd_prev <= 1'b0;
      end else begin
         wr_prev <= wr_act;
         rd_prev <= rd_act;
      end
   end

   assign wr_go     = wr_act & ~wr_prev;
   assign rd_go     = rd_act & ~rd_prev;
   assign rd_active = rd_act;
endmodule

// File: rtl/hbus_wait.sv
module hbus_wait #(
   parameter int WAIT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy_n,
   output logic last
);
   localparam int CW = $clog2(WAIT_CYC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (start)         cnt <= CW'(WAIT_CYC);
      else if (cnt != '0)     cnt <= cnt - CW'(1);
   end

   assign busy_n = (cnt != '0);
   assign last   = (cnt == CW'(1));
endmodule

// File: rtl/hbus_irq.sv
module hbus_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic clr_i,
   input  logic en_i,
   output logic pend_o,
   output logic irq_n_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_o <= 1'b0;
      else if (event_i) pend_o <= 1'b1;
      else if (clr_i)   pend_o <= 1'b0;
   end

   assign irq_n_o = ~(pend_o & en_i);
endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
   import hbus_pkg::*;
#(
   parameter logic [7:0] REV        = 8'h15,
   parameter int         IRQ_EN_BIT = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_go,
   input  logic        rd_go,
   input  logic        rd_last,
   input  logic        sel,
   input  logic [7:0]  din,
   input  logic        irq_pend,
   input  logic [7:0]  ext_rdata,
   output logic [7:0]  dout,
   output logic        irq_en,
   output logic        irq_clr,
   output logic [1:0]  ts_en,
   output logic [1:0]  tuner_rst_n,
   output logic [15:0] cam_addr,
   output logic [15:0] pid_addr,
   output logic [7:0]  div_a,
   output logic [7:0]  div_b,
   output logic        ext_wr,
   output logic        ext_rd,
   output logic [1:0]  ext_sel,
   output logic [7:0]  ext_wdata
);
   logic [7:0] idx_q;
   logic [7:1] intctl_q;
   logic [7:0] bc2_q;
   logic [7:0] cam_lo_q, cam_hi_q, pid_lo_q, pid_hi_q, div_a_q, div_b_q;
   logic       rd_ext_q;
   logic [7:0] local_rd;
   ext_dec_t   dec;

   assign dec = ext_decode(idx_q);

   always_comb begin
      case (idx_q)
         IDX_INTCTL:    local_rd = {intctl_q, irq_pend};
         IDX_BUSCTL2:   local_rd = bc2_q;
         IDX_CAMADR_LO: local_rd = cam_lo_q;
         IDX_CAMADR_HI: local_rd = cam_hi_q;
         IDX_PIDADR_LO: local_rd = pid_lo_q;
         IDX_PIDADR_HI: local_rd = pid_hi_q;
         IDX_DIV_A:     local_rd = div_a_q;
         IDX_DIV_B:     local_rd = div_b_q;
         IDX_REV:       local_rd = REV;
         default:       local_rd = 8'h00;
      endcase
   end

   // register index latch and local register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         intctl_q <= '0;
         bc2_q    <= '0;
         cam_lo_q <= '0;
         cam_hi_q <= '0;
         pid_lo_q <= '0;
         pid_hi_q <= '0;
         div_a_q  <= '0;
         div_b_q  <= '0;
      end else if (wr_go) begin
         if (sel) begin
            idx_q <= din;
         end else begin
            case (idx_q)
               IDX_INTCTL:    intctl_q <= din[7:1];
               IDX_BUSCTL2:   bc2_q    <= din;
               IDX_CAMADR_LO: cam_lo_q <= din;
               IDX_CAMADR_HI: cam_hi_q <= din;
               IDX_PIDADR_LO: pid_lo_q <= din;
               IDX_PIDADR_HI: pid_hi_q <= din;
               IDX_DIV_A:     div_a_q  <= din;
               IDX_DIV_B:     div_b_q  <= din;
               default: ;
            endcase
         end
      end
   end

   // forwarding port and read data path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_wr    <= 1'b0;
         ext_rd    <= 1'b0;
         ext_sel   <= '0;
         ext_wdata <= '0;
         rd_ext_q  <= 1'b0;
         dout      <= '0;
      end else begin
         ext_wr <= 1'b0;
         ext_rd <= 1'b0;
         if (wr_go) begin
            rd_ext_q <= 1'b0;
            if (!sel && dec.is_ext) begin
               ext_wr    <= 1'b1;
               ext_sel   <= dec.code;
               ext_wdata <= din;
            end
         end else if (rd_go) begin
            if (sel) begin
               dout     <= idx_q;
               rd_ext_q <= 1'b0;
            end else begin
               dout     <= local_rd;
               rd_ext_q <= dec.is_ext;
               if (dec.is_ext) begin
                  ext_rd  <= 1'b1;
                  ext_sel <= dec.code;
               end
            end
         end else if (rd_last && rd_ext_q) begin
            dout     <= ext_rdata;
            rd_ext_q <= 1'b0;
         end
      end
   end

   assign irq_clr     = rd_go & ~sel & (idx_q == IDX_INTCTL);
   assign irq_en      = intctl_q[IRQ_EN_BIT];
   assign ts_en       = bc2_q[5:4];
   assign tuner_rst_n = bc2_q[3:2];
   assign cam_addr    = {cam_hi_q, cam_lo_q};
   assign pid_addr    = {pid_hi_q, pid_lo_q};
   assign div_a       = div_a_q;
   assign div_b       = div_b_q;
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif #(
   parameter int         DW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         WAIT_CYC    = 4,
   parameter logic [7:0] REV         = 8'h15,
   parameter int         IRQ_EN_BIT  = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_cs_n,
   input  logic        bus_wr_n,
   input  logic        bus_rd_n,
   input  logic        bus_sel,
   input  logic [7:0]  bus_din,
   output logic [7:0]  bus_dout,
   output logic        bus_oe,
   output logic        bus_rdy_n,
   input  logic        irq_event,
   output logic        irq_n,
   output logic [1:0]  ts_en,
   output logic [1:0]  tuner_rst_n,
   output logic [15:0] cam_addr,
   output logic [15:0] pid_addr,
   output logic [7:0]  div_a,
   output logic [7:0]  div_b,
   output logic        ext_wr,
   output logic        ext_rd,
   output logic [1:0]  ext_sel,
   output logic [7:0]  ext_wdata,
   input  logic [7:0]  ext_rdata
);
   localparam int NSTB = 3;

   if (DW != 8) begin : g_bad_dw
      $error("hbus_regif: the register map assumes an 8-bit bus");
   end
   if (WAIT_CYC < 2) begin : g_bad_wait
      $error("hbus_regif: WAIT_CYC must be at least 2");
   end
   if (IRQ_EN_BIT < 1 || IRQ_EN_BIT > 7) begin : g_bad_irqbit
      $error("hbus_regif: IRQ_EN_BIT must be within 7:1");
   end

   logic [NSTB-1:0] stb_s;
   logic wr_go, rd_go, rd_active, rd_last;
   logic irq_clr, irq_en, irq_pend;

   hbus_sync #(.STAGES(SYNC_STAGES), .N(NSTB), .RESET_VAL('1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({bus_cs_n, bus_wr_n, bus_rd_n}),
      .sync_o  (stb_s)
   );

   hbus_strobe u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (stb_s[2]),
      .wr_n_s    (stb_s[1]),
      .rd_n_s    (stb_s[0]),
      .wr_go     (wr_go),
      .rd_go     (rd_go),
      .rd_active (rd_active)
   );

   hbus_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (wr_go | rd_go),
      .busy_n (bus_rdy_n),
      .last   (rd_last)
   );

   hbus_regs #(.REV(REV), .IRQ_EN_BIT(IRQ_EN_BIT)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_go       (wr_go),
      .rd_go       (rd_go),
      .rd_last     (rd_last),
      .sel         (bus_sel),
      .din         (bus_din),
      .irq_pend    (irq_pend),
      .ext_rdata   (ext_rdata),
      .dout        (bus_dout),
      .irq_en      (irq_en),
      .irq_clr     (irq_clr),
      .ts_en       (ts_en),
      .tuner_rst_n (tuner_rst_n),
      .cam_addr    (cam_addr),
      .pid_addr    (pid_addr),
      .div_a       (div_a),
      .div_b       (div_b),
      .ext_wr      (ext_wr),
      .ext_rd      (ext_rd),
      .ext_sel     (ext_sel),
      .ext_wdata   (ext_wdata)
   );

   hbus_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (irq_event),
      .clr_i   (irq_clr),
      .en_i    (irq_en),
      .pend_o  (irq_pend),
      .irq_n_o (irq_n)
   );

   assign bus_oe = rd_active;
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_go,
   input logic       rd_go,
   input logic       bus_rdy_n,
   input logic       ext_wr,
   input logic       ext_rd,
   input logic       irq_clr,
   input logic       irq_event,
   input logic       irq_n,
   input logic [1:0] ts_en,
   input logic [1:0] tuner_rst_n
);
   // R7: an accepted strobe makes the port busy on the next cycle
   a_r7_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go || rd_go) |=> bus_rdy_n);

   // R1 / R4: a forwarded write never lasts more than one cycle
   a_r1_single_ext_wr: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr |=> !ext_wr);

   // R4: forwarded read and write are exclusive
   a_r4_ext_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_wr && ext_rd));

   // R8: acknowledging read without a new event releases the interrupt
   a_r8_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !irq_event) |=> irq_n);

   // R10: stream enables and tuner resets move only on a write
   a_r10_ctl2_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_go |=> ($stable(ts_en) && $stable(tuner_rst_n)));
endmodule

bind hbus_regif hbus_regif_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_go       (wr_go),
   .rd_go       (rd_go),
   .bus_rdy_n   (bus_rdy_n),
   .ext_wr      (ext_wr),
   .ext_rd      (ext_rd),
   .irq_clr     (irq_clr),
   .irq_event   (irq_event),
   .irq_n       (irq_n),
   .ts_en       (ts_en),
   .tuner_rst_n (tuner_rst_n)
);

// File: tb/hbus_regif_tb.sv
module hbus_regif_tb;
   localparam int         WAIT = 4;
   localparam logic [7:0] REV  = 8'h15;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_sel;
   logic [7:0]  bus_din, bus_dout;
   logic        bus_oe, bus_rdy_n, irq_event, irq_n;
   logic [1:0]  ts_en, tuner_rst_n, ext_sel;
   logic [15:0] cam_addr, pid_addr;
   logic [7:0]  div_a, div_b, ext_wdata, ext_rdata;
   logic        ext_wr, ext_rd;

   // forwarded registers answer with 0x30 plus their code
   assign ext_rdata = 8'h30 + {6'd0, ext_sel};

   hbus_regif #(.WAIT_CYC(WAIT), .REV(REV)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
      .bus_rd_n(bus_rd_n), .bus_sel(bus_sel), .bus_din(bus_din),
      .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_rdy_n(bus_rdy_n),
      .irq_event(irq_event), .irq_n(irq_n), .ts_en(ts_en),
      .tuner_rst_n(tuner_rst_n), .cam_addr(cam_addr), .pid_addr(pid_addr),
      .div_a(div_a), .div_b(div_b), .ext_wr(ext_wr), .ext_rd(ext_rd),
      .ext_sel(ext_sel), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
   );

   int checks = 0;
   int fails  = 0;
   int n_ext_wr = 0;
   int n_ext_rd = 0;
   logic [7:0] last_wdata = '0;
   logic [1:0] last_wsel  = '0;

   always @(negedge clk) begin
      if (ext_wr) begin
         n_ext_wr++;
         last_wdata = ext_wdata;
         last_wsel  = ext_sel;
      end
      if (ext_rd) n_ext_rd++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one bus cycle; also checks the R7 busy window
   task automatic bus_op(input bit sel, input bit wr, input logic [7:0] d,
                         input int hold, output logic [7:0] q);
      logic b_first, b_late, b_idle;
      @(negedge clk);
      bus_sel = sel; bus_din = d; bus_cs_n = 1'b0;
      if (wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      b_first = bus_rdy_n;
      repeat (WAIT - 1) @(negedge clk);
      b_late = bus_rdy_n;
      @(negedge clk);
      b_idle = bus_rdy_n;
      q = bus_dout;
      chk(b_first == 1'b1 && b_late == 1'b1 && b_idle == 1'b0, "R7 ready window",
          {b_first, b_late, b_idle}, 3'b110);
      repeat (hold) begin
         @(negedge clk);
         chk(bus_rdy_n == 1'b0, "R7 ready stays low", bus_rdy_n, 0);
      end
      bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   function automatic bit is_ext(input int idx);
      return idx == 6 || idx == 7 || idx == 10;
   endfunction

   // expected read after the sweep wrote idx ^ 0xA5 everywhere
   function automatic logic [7:0] exp_read(input int idx);
      logic [7:0] v = 8'(idx) ^ 8'hA5;
      case (idx)
         0:                       return v & 8'hFE;
         1, 4, 5, 8, 9, 12, 13:   return v;
         6:                       return 8'h30;
         7:                       return 8'h31;
         10:                      return 8'h32;
         15:                      return REV;
         default:                 return 8'h00;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] q;
      int w0, r0;
      rst_n = 1'b0; bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1;
      bus_sel = 1'b0; bus_din = '0; irq_event = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk(irq_n == 1'b1, "R9 irq_n", irq_n, 1);
      chk(bus_rdy_n == 1'b0, "R9 rdy_n", bus_rdy_n, 0);
      chk(ts_en == 2'b00 && tuner_rst_n == 2'b00, "R9 ctl2 outputs", {ts_en, tuner_rst_n}, 0);
      chk(cam_addr == 16'h0 && pid_addr == 16'h0 && div_a == 8'h0 && div_b == 8'h0,
          "R9 address and dividers", cam_addr, 0);
      bus_op(1'b0, 1'b0, 8'h00, 0, q);
      chk(q == 8'h00, "R9 index 0 after reset", q, 0);
      bus_op(1'b1, 1'b0, 8'h00, 0, q);
      chk(q == 8'h00, "R9 index latch after reset", q, 0);

      // R10 bus control 2 field positions
      bus_op(1'b1, 1'b1, 8'h01, 0, q);
      bus_op(1'b0, 1'b1, 8'h34, 0, q);
      chk(ts_en == 2'b11, "R10 ts_en", ts_en, 3);
      chk(tuner_rst_n == 2'b01, "R10 tuner_rst_n", tuner_rst_n, 1);

      // R2 index write and read-back
      bus_op(1'b1, 1'b1, 8'h5A, 0, q);
      bus_op(1'b1, 1'b0, 8'h00, 0, q);
      chk(q == 8'h5A, "R2 index read-back", q, 8'h5A);

      // R3 R4 R5 R6 sweep of all indices: write
      for (int i = 0; i < 256; i++) begin
         bus_op(1'b1, 1'b1, 8'(i), 0, q);
         w0 = n_ext_wr;
         bus_op(1'b0, 1'b1, 8'(i) ^ 8'hA5, 0, q);
         if (is_ext(i))
            chk(n_ext_wr - w0 == 1, "R4 forwarded write pulse", n_ext_wr - w0, 1);
         else
            chk(n_ext_wr - w0 == 0, "R6 no forward on non-forwarded index", n_ext_wr - w0, 0);
      end
      chk(last_wdata == 8'hAF && last_wsel == 2'd2, "R4 last forwarded byte and code",
          {last_wsel, last_wdata}, {2'd2, 8'hAF});
      chk(cam_addr == 16'hA0A1, "R3 cam_addr", cam_addr, 16'hA0A1);
      chk(pid_addr == 16'hACAD, "R3 pid_addr", pid_addr, 16'hACAD);
      chk(div_a == 8'hA9 && div_b == 8'hA8, "R3 dividers", {div_a, div_b}, 16'hA9A8);
      chk(ts_en == 2'b10 && tuner_rst_n == 2'b01, "R10 after sweep", {ts_en, tuner_rst_n}, 4'b1001);

      // sweep: read back every index
      r0 = n_ext_rd;
      for (int i = 0; i < 256; i++) begin
         bus_op(1'b1, 1'b1, 8'(i), 0, q);
         bus_op(1'b0, 1'b0, 8'h00, 0, q);
         chk(q == exp_read(i), $sformatf("R3/R4/R5/R6 read idx 0x%02h", i), q, exp_read(i));
      end
      chk(n_ext_rd - r0 == 3, "R4 forwarded read pulses", n_ext_rd - r0, 3);

      // R1 long strobe gives a single access
      bus_op(1'b1, 1'b1, 8'h07, 0, q);
      w0 = n_ext_wr;
      bus_op(1'b0, 1'b1, 8'h5C, 40, q);
      chk(n_ext_wr - w0 == 1, "R1 one access per long strobe", n_ext_wr - w0, 1);
      chk(last_wdata == 8'h5C && last_wsel == 2'd1, "R1 long strobe data",
          {last_wsel, last_wdata}, {2'd1, 8'h5C});

      // R8 interrupt enabled
      bus_op(1'b1, 1'b1, 8'h00, 0, q);
      bus_op(1'b0, 1'b1, 8'h44, 0, q);
      chk(irq_n == 1'b1, "R8 no irq before event", irq_n, 1);
      @(negedge clk); irq_event = 1'b1;
      @(negedge clk); irq_event = 1'b0;
      chk(irq_n == 1'b0, "R8 irq asserted", irq_n, 0);
      bus_op(1'b0, 1'b0, 8'h00, 0, q);
      chk(q == 8'h45, "R8 read with pending", q, 8'h45);
      chk(irq_n == 1'b1, "R8 irq released by read", irq_n, 1);
      bus_op(1'b0, 1'b0, 8'h00, 0, q);
      chk(q == 8'h44, "R8 pending cleared", q, 8'h44);

      // R8 interrupt disabled
      bus_op(1'b0, 1'b1, 8'h00, 0, q);
      @(negedge clk); irq_event = 1'b1;
      @(negedge clk); irq_event = 1'b0;
      chk(irq_n == 1'b1, "R8 masked irq", irq_n, 1);
      bus_op(1'b0, 1'b0, 8'h00, 0, q);
      chk(q == 8'h01, "R8 pending visible while masked", q, 8'h01);
      bus_op(1'b0, 1'b0, 8'h00, 0, q);
      chk(q == 8'h00, "R8 masked pending cleared", q, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule